// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer reached through a small word-addressed register bus. Software arms it by writing a configuration word to a mode register and a reload/prescale word to a counter-control register. Each of these writes lands only if the word carries the right access key in a fixed upper field, so stray stores cannot reprogram or silence the watchdog. Once enabled, a down-counter loads from a coarse reload field padded with ones in its low bits and steps down once per prescaler tick. Software must write one exact magic word to the restart register before the count runs out.

When the counter reaches zero the block latches an expired flag, visible in the status register. Depending on the mode bits it then drives a reset pulse of a chosen length, a level interrupt, or both. The counter is governed by a three-state machine. From `CS_OFF` it goes to `CS_RUN` on an enable write. `CS_RUN` reloads on a valid restart and goes to `CS_EXPIRED` when a tick takes the count from one to zero. `CS_EXPIRED` returns to `CS_RUN` on a valid restart. Both `CS_RUN` and `CS_EXPIRED` go to `CS_OFF` on a keyed write that clears the enable bit.

The reset pulse has its own two-state machine. It moves from `PS_IDLE` to `PS_DRIVE` on the expiry cycle when the reset output is enabled, and returns to `PS_IDLE` once the programmed length has elapsed.

Top module: `keyed_wdt`

## Requirements
- R1: Register offsets are mode 0x0, counter control 0x4, restart 0x8 and status 0xC. Reads return the stored fields with zeros elsewhere, and the restart register reads as zero.
- R2: A write to the mode register takes effect only when bits [23:12] equal 0xABC. Any other write there leaves the mode register unchanged.
- R3: A write to the counter-control register takes effect only when bits [25:14] equal 0x248, which is the word pattern 0x00920000. Any other write there leaves the register unchanged.
- R4: Mode bit 0 enables counting, bit 1 enables the reset output on timeout, and bit 2 enables the interrupt output on timeout.
- R5: Counter-control bits [13:2] hold the reload field and bits [1:0] select the prescaler. Selects 0, 1, 2 and 3 divide by 2^PSH0 through 2^PSH3, which by default are 8, 64, 512 and 4096.
- R6: On an enable (a keyed mode write with bit 0 set while disabled) or on a valid restart, the counter loads {reload, FILL_W ones}. Expiry occurs exactly L×D clock edges after the edge that accepted the write, where L is the loaded value and D is the divisor.
- R7: Only a write of exactly 0x00001999 to the restart register reloads the counter, and only while enabled. Any other value has no effect.
- R8: Status bit 0 is set at expiry. It clears on a valid restart or when enable is cleared.
- R9: Mode bits [5:4] set the reset pulse width: 0, 1, 2 and 3 give 2, 4, 8 and 16 clock cycles. The pulse starts on the expiry edge, occurs once per expiry event, and only when bit 1 is set.
- R10: The interrupt output is high while the block is expired and bit 2 is set.
- R11: While enable is clear no expiry can occur. A later enable restarts a full count.
- R12: After reset, both outputs are low, the mode register is 0, the counter-control register holds reload all ones with select 0, and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Timeout interrupt level |
| rst_pulse_o | output | 1 | Timeout reset pulse |

## Verification
The bench builds the block with FILL_W=2 and prescaler shifts of 1, 2, 3 and 4, so the dividers become 2, 4, 8 and 16 and a loaded count is 4×reload+3. With these values every prescaler select, every pulse-width encoding, early and late restarts and disable/re-enable sequences all finish within tens of cycles. The expiry edge can therefore be predicted exactly and checked one cycle before and at the edge. Key rejection is checked by reading back the targeted register and by watching status and outputs stay quiet.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [11:0] MODE_KEY  = 12'hABC;
    localparam logic [11:0] CTRL_KEY  = 12'h248;
    localparam logic [31:0] KICK_WORD = 32'h0000_1999;

    localparam logic [3:0] OFF_MODE = 4'h0;
    localparam logic [3:0] OFF_CTRL = 4'h4;
    localparam logic [3:0] OFF_KICK = 4'h8;
    localparam logic [3:0] OFF_STAT = 4'hC;

    localparam int PULSE_W = 4;

    typedef enum logic [1:0] {
        CS_OFF,
        CS_RUN,
        CS_EXPIRED
    } cnt_state_e;

    typedef enum logic {
        PS_IDLE,
        PS_DRIVE
    } pulse_state_e;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                expired,
    output mode_t               mode_q,
    output logic [RELOAD_W-1:0] reload_q,
    output logic [1:0]          psel_q,
    output logic                load_req,
    output logic                stop_req,
    output logic [31:0]         bus_rdata
);

    localparam int KEY_LO = RELOAD_W + 2;
    localparam int KEY_HI = KEY_LO + 11;

    logic hit_mode, hit_ctrl, hit_kick, hit_stat;
    logic mode_ok, ctrl_ok, kick_ok;

    always_comb begin
        hit_mode = (bus_addr == ADDR_W'(OFF_MODE));
        hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_kick = (bus_addr == ADDR_W'(OFF_KICK));
        hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
        mode_ok  = bus_wr && hit_mode && (bus_wdata[23:12] == MODE_KEY);
        ctrl_ok  = bus_wr && hit_ctrl && (bus_wdata[KEY_HI:KEY_LO] == CTRL_KEY);
        kick_ok  = bus_wr && hit_kick && (bus_wdata == KICK_WORD);
        load_req = (mode_ok && bus_wdata[0] && !mode_q.en) || (kick_ok && mode_q.en);
        stop_req = mode_ok && !bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_ok) begin
            mode_q.en     <= bus_wdata[0];
            mode_q.rst_en <= bus_wdata[1];
            mode_q.irq_en <= bus_wdata[2];
            mode_q.plen   <= bus_wdata[5:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            psel_q   <= 2'd0;
        end else if (ctrl_ok) begin
            reload_q <= bus_wdata[RELOAD_W+1:2];
            psel_q   <= bus_wdata[1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_mode) begin
            bus_rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
        end else if (hit_ctrl) begin
            bus_rdata = 32'({reload_q, psel_q});
        end else if (hit_stat) begin
            bus_rdata = {31'd0, expired};
        end
    end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PSH0 = 3,
    parameter int PSH1 = 6,
    parameter int PSH2 = 9,
    parameter int PSH3 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int PSC_W = max4(PSH0, PSH1, PSH2, PSH3);

    localparam logic [PSC_W-1:0] MASK0 = PSC_W'((64'd1 << PSH0) - 64'd1);
    localparam logic [PSC_W-1:0] MASK1 = PSC_W'((64'd1 << PSH1) - 64'd1);
    localparam logic [PSC_W-1:0] MASK2 = PSC_W'((64'd1 << PSH2) - 64'd1);
    localparam logic [PSC_W-1:0] MASK3 = PSC_W'((64'd1 << PSH3) - 64'd1);

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] mask;

    always_comb begin
        unique case (sel)
            2'd0: mask = MASK0;
            2'd1: mask = MASK1;
            2'd2: mask = MASK2;
            default: mask = MASK3;
        endcase
        tick = run && !clear && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_count_fsm.sv
module wdt_count_fsm
    import wdt_pkg::*;
#(
    parameter int RELOAD_W = 12,
    parameter int FILL_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                load_req,
    input  logic                stop_req,
    input  logic [RELOAD_W-1:0] reload,
    output logic                running,
    output logic                expired,
    output logic                expire_now
);

    localparam int CNT_W = RELOAD_W + FILL_W;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_step;

    assign last_step = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_OFF: begin
                if (load_req) state_d = CS_RUN;
            end
            CS_RUN: begin
                if (stop_req)       state_d = CS_OFF;
                else if (load_req)  state_d = CS_RUN;
                else if (last_step) state_d = CS_EXPIRED;
            end
            CS_EXPIRED: begin
                if (stop_req)      state_d = CS_OFF;
                else if (load_req) state_d = CS_RUN;
            end
            default: state_d = CS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_req && !stop_req) begin
            cnt_q <= {reload, {FILL_W{1'b1}}};
        end else if (state_q == CS_RUN && tick && !stop_req) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        running    = (state_q == CS_RUN);
        expired    = (state_q == CS_EXPIRED);
        expire_now = (state_q == CS_RUN) && !stop_req && !load_req && last_step;
    end

endmodule

// File: rtl/wdt_pulse_fsm.sv
module wdt_pulse_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire_now,
    input  logic       rst_en,
    input  logic [1:0] plen,
    output logic       pulse_o
);

    pulse_state_e       state_q, state_d;
    logic [PULSE_W-1:0] left_q;
    logic [PULSE_W-1:0] first_left;

    always_comb begin
        unique case (plen)
            2'd0: first_left = PULSE_W'(1);
            2'd1: first_left = PULSE_W'(3);
            2'd2: first_left = PULSE_W'(7);
            default: first_left = PULSE_W'(15);
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (expire_now && rst_en) state_d = PS_DRIVE;
            PS_DRIVE: if (left_q == '0)         state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (state_q == PS_IDLE) begin
            left_q <= first_left;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o = (state_q == PS_DRIVE);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int RELOAD_W = 12,
    parameter int FILL_W   = 12,
    parameter int PSH0     = 3,
    parameter int PSH1     = 6,
    parameter int PSH2     = 9,
    parameter int PSH3     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              rst_pulse_o
);

    mode_t               mode_q;
    logic [RELOAD_W-1:0] reload_q;
    logic [1:0]          psel_q;
    logic                load_req, stop_req;
    logic                tick, running, expired, expire_now;

    wdt_regfile #(.ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .expired(expired),
        .mode_q(mode_q), .reload_q(reload_q), .psel_q(psel_q),
        .load_req(load_req), .stop_req(stop_req),
        .bus_rdata(bus_rdata)
    );

    wdt_prescaler #(.PSH0(PSH0), .PSH1(PSH1), .PSH2(PSH2), .PSH3(PSH3)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .run(running), .clear(load_req), .sel(psel_q),
        .tick(tick)
    );

    wdt_count_fsm #(.RELOAD_W(RELOAD_W), .FILL_W(FILL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .load_req(load_req), .stop_req(stop_req),
        .reload(reload_q),
        .running(running), .expired(expired), .expire_now(expire_now)
    );

    wdt_pulse_fsm u_pulse (
        .clk(clk), .rst_n(rst_n),
        .expire_now(expire_now), .rst_en(mode_q.rst_en), .plen(mode_q.plen),
        .pulse_o(rst_pulse_o)
    );

    assign irq_o = expired && mode_q.irq_en;

endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CTRL_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [4:0]        mode_bits,
    input logic [CTRL_W-1:0] ctrl_bits,
    input logic              expired,
    input logic              irq_o,
    input logic              rst_o
);

    logic [4:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_run <= '0;
        else if (rst_o) hi_run <= hi_run + 1'b1;
        else            hi_run <= '0;
    end

    assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_MODE) && bus_wdata[23:12] != MODE_KEY)
        |=> $stable(mode_bits));

    assert_ctrl_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[CTRL_W+11:CTRL_W] != CTRL_KEY)
        |=> $stable(ctrl_bits));

    assert_bad_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && bus_wr && bus_addr == ADDR_W'(OFF_KICK) && bus_wdata != KICK_WORD)
        |=> expired);

    assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[0] && bus_wr && bus_addr == ADDR_W'(OFF_KICK) && bus_wdata == KICK_WORD)
        |=> !expired);

    assert_pulse_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> (hi_run < 5'd16));

    assert_pulse_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> expired);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($rose(expired) || $rose(mode_bits[2])));

    assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bits[0] |-> !expired);

endmodule

bind keyed_wdt wdt_checks #(.ADDR_W(ADDR_W), .CTRL_W(RELOAD_W + 2)) u_checks (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .mode_bits(mode_q), .ctrl_bits({reload_q, psel_q}),
    .expired(expired), .irq_o(irq_o), .rst_o(rst_pulse_o)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_pulse_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    keyed_wdt #(.ADDR_W(4), .RELOAD_W(12), .FILL_W(2),
                .PSH0(1), .PSH1(2), .PSH2(3), .PSH3(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_mode(input logic [5:0] bits);
        wr(4'h0, 32'h00ABC000 | {26'd0, bits});
    endtask

    task automatic wr_ctrl(input logic [11:0] reload, input logic [1:0] sel);
        wr(4'h4, 32'h00920000 | {18'd0, reload, sel});
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_expiry(input int n, input string tag);
        logic [31:0] s;
        repeat (n - 1) @(posedge clk);
        @(negedge clk);
        rd(4'hC, s);
        chk({tag, " one edge before expiry"}, s, 32'd0);
        @(posedge clk);
        @(negedge clk);
        rd(4'hC, s);
        chk({tag, " at expiry edge"}, s, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 rst_pulse_o after reset", {31'd0, rst_pulse_o}, 32'd0);
        chk("R12 irq_o after reset", {31'd0, irq_o}, 32'd0);
        rd(4'h0, d); chk("R12 R1 mode reset value", d, 32'd0);
        rd(4'h4, d); chk("R12 R1 ctrl reset value", d, 32'h0000_3FFC);
        rd(4'hC, d); chk("R12 R1 status reset value", d, 32'd0);
        rd(4'h8, d); chk("R1 restart reads zero", d, 32'd0);
    endtask

    task automatic t_mode_key();
        logic [31:0] d;
        wr(4'h0, 32'h00ABD007);
        rd(4'h0, d); chk("R2 wrong mode key ignored", d, 32'd0);
        cycles(60);
        rd(4'hC, d); chk("R2 no expiry after rejected enable", d, 32'd0);
        wr_mode(6'h34);
        rd(4'h0, d); chk("R2 R4 keyed mode write stored", d, 32'h34);
        wr_mode(6'h00);
    endtask

    task automatic t_ctrl_key();
        logic [31:0] d;
        wr(4'h4, 32'h00930015);
        rd(4'h4, d); chk("R3 wrong ctrl key ignored", d, 32'h0000_3FFC);
        wr_ctrl(12'd5, 2'd1);
        rd(4'h4, d); chk("R3 R5 keyed ctrl write stored", d, 32'h15);
    endtask

    task automatic t_timeout_irq();
        logic [31:0] d;
        wr_ctrl(12'd1, 2'd0);
        wr_mode(6'h05);
        expect_expiry(14, "R6 R8 reload1 sel0");
        chk("R10 irq high when expired", {31'd0, irq_o}, 32'd1);
        chk("R4 no reset pulse when disabled", {31'd0, rst_pulse_o}, 32'd0);
        wr(4'h8, 32'h0000_1999);
        rd(4'hC, d); chk("R8 R7 restart clears status", d, 32'd0);
        chk("R10 irq low after restart", {31'd0, irq_o}, 32'd0);
        expect_expiry(14, "R6 count after restart");
        wr_mode(6'h00);
        rd(4'hC, d); chk("R8 disable clears status", d, 32'd0);
    endtask

    task automatic t_prescale();
        wr_ctrl(12'd0, 2'd3);
        wr_mode(6'h01);
        expect_expiry(48, "R5 R6 sel3 reload0");
        wr_mode(6'h00);
        wr_ctrl(12'd2, 2'd1);
        wr_mode(6'h01);
        expect_expiry(44, "R5 R6 sel1 reload2");
        wr_mode(6'h00);
        wr_ctrl(12'd0, 2'd2);
        wr_mode(6'h01);
        expect_expiry(24, "R5 R6 sel2 reload0");
        wr_mode(6'h00);
    endtask

    task automatic t_restart_keys();
        logic [31:0] d;
        wr_ctrl(12'd1, 2'd0);
        wr_mode(6'h01);
        cycles(5);
        wr(4'h8, 32'h0000_1998);
        expect_expiry(8, "R7 wrong restart word ignored");
        wr(4'h8, 32'h0001_1999);
        rd(4'hC, d); chk("R7 near-miss restart keeps expired", d, 32'd1);
        wr(4'h8, 32'h0000_1999);
        cycles(5);
        wr(4'h8, 32'h0000_1999);
        expect_expiry(14, "R7 exact restart reloads");
        wr_mode(6'h00);
        wr(4'h8, 32'h0000_1999);
        cycles(40);
        rd(4'hC, d); chk("R7 R11 restart while disabled has no effect", d, 32'd0);
    endtask

    task automatic t_pulse();
        for (int k = 0; k < 4; k++) begin
            int hi;
            hi = 0;
            wr_ctrl(12'd0, 2'd0);
            wr_mode({k[1:0], 4'h3});
            expect_expiry(6, "R9 pulse run");
            while (rst_pulse_o && hi < 40) begin
                hi++;
                @(posedge clk);
                @(negedge clk);
            end
            chk("R9 reset pulse width", 32'(hi), 32'(2 << k));
            cycles(20);
            chk("R9 single pulse per expiry", {31'd0, rst_pulse_o}, 32'd0);
            chk("R10 irq stays low without irq enable", {31'd0, irq_o}, 32'd0);
            wr_mode(6'h00);
        end
    endtask

    task automatic t_disable_hold();
        logic [31:0] d;
        wr_ctrl(12'd1, 2'd0);
        wr_mode(6'h05);
        cycles(5);
        wr_mode(6'h04);
        cycles(40);
        rd(4'hC, d); chk("R11 no expiry while disabled", d, 32'd0);
        chk("R11 irq quiet while disabled", {31'd0, irq_o}, 32'd0);
        wr_mode(6'h05);
        expect_expiry(14, "R11 re-enable gives full count");
        chk("R10 irq after re-enable expiry", {31'd0, irq_o}, 32'd1);
        wr_mode(6'h00);
        chk("R8 R10 irq drops on disable", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_key();
        t_ctrl_key();
        t_timeout_irq();
        t_prescale();
        t_restart_keys();
        t_pulse();
        t_disable_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule